// File: doc/BRIEF.md
# Interrupt Flag and Enable Register

This block collects seven interrupt sources into one request line for a peripheral. Each source delivers a one-cycle set pulse when its event happens and a one-cycle clear pulse when software performs the access that acknowledges it. A pending flag stays latched between those two pulses. Software sees the flags through a read-only flag register. It chooses which flags may raise the request through an enable register.

The enable register is written with a mask protocol, so one source can be switched on or off without reading the register first. The top data bit carries the value to apply. The lower seven bits select the enable bits that take that value. The top bit of the flag register reports whether any enabled flag is pending. An interrupt handler can therefore test the sign bit to tell whether this device raised the request.

Generating the source events is outside this block. Only the set and clear pulses reach it.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all flags and all enables are 0, `irq` is 0, the flag register reads 0x00 and the enable register reads 0x80.
- R2: A pulse on `src_set[i]` sets flag bit i in the next cycle, and the flag then holds without further pulses. The source order from bit 0 upward is: port A control line 2, port A control line 1, shift register, port B control line 2, port B control line 1, timer 2, timer 1.
- R3: A pulse on `src_clr[i]` clears flag bit i in the next cycle and affects no other flag.
- R4: When `src_set[i]` and `src_clr[i]` are both high in the same cycle, flag i is 1 afterwards.
- R5: A write to address 0xE with data bit 7 = 1 sets every enable bit whose position holds a 1 in data bits 6..0. All other enable bits are left unchanged. For example, writing 0x81 enables source 0.
- R6: A write to address 0xE with data bit 7 = 0 clears every enable bit whose position holds a 1 in data bits 6..0. All other enable bits are left unchanged. For example, writing 0x01 disables source 0.
- R7: `irq` is 1 exactly when at least one flag is set and its enable bit is 1. It follows the registered state in the same cycle.
- R8: Reading address 0xD returns the seven raw flags in bits 6..0, whether or not they are enabled. Bit 7 equals `irq`.
- R9: Reading address 0xE returns 1 in bit 7 and the current enables in bits 6..0.
- R10: Writes to any address other than 0xE, including 0xD, change neither the flags nor the enables.
- R11: Reading any address other than 0xD or 0xE returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 7 | Per-source set pulses |
| src_clr | input | 7 | Per-source clear pulses |
| reg_addr | input | 4 | Register bus address |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request, active high |

## Verification
Directed cases cover the following:
- the reset values;
- the 0x81 and 0x01 enable writes;
- a set and a clear on the same flag in the same cycle;
- a write to the flag register address, which must be ignored.

These separate mask-protocol faults and set/clear priority faults from plain storage faults.

Random cycles then mix sparse set pulses, clear pulses and bus writes to random addresses with random data. Because flags can be pending while disabled, this stimulus tells apart a summary bit and request output that gate with the enables from ones that report raw flags. Each cycle the bench reads back both registers and compares them with its own model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned IRQ_NSRC = 7;
    localparam int unsigned IRQ_AW   = 4;

    // source positions inside the flag and enable registers
    typedef enum logic [2:0] {
        SRC_PA_LINE2 = 3'd0,
        SRC_PA_LINE1 = 3'd1,
        SRC_SHIFT    = 3'd2,
        SRC_PB_LINE2 = 3'd3,
        SRC_PB_LINE1 = 3'd4,
        SRC_TMR2     = 3'd5,
        SRC_TMR1     = 3'd6
    } irq_src_e;

    // mask-protocol update: top bit is the value, lower bits select
    function automatic logic [IRQ_NSRC-1:0] apply_mask(
        input logic [IRQ_NSRC-1:0] cur,
        input logic [IRQ_NSRC:0]   cmd
    );
        if (cmd[IRQ_NSRC]) return cur | cmd[IRQ_NSRC-1:0];
        else               return cur & ~cmd[IRQ_NSRC-1:0];
    endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned NSRC = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_p,
    input  logic [NSRC-1:0] clr_p,
    output logic [NSRC-1:0] flags
);
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags[i] <= 1'b0;
            else if (set_p[i]) flags[i] <= 1'b1;   // set has priority
            else if (clr_p[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
#(
    parameter int unsigned NSRC = IRQ_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb,
    input  logic [NSRC:0]   wdata,
    output logic [NSRC-1:0] enables
);
    logic [NSRC-1:0] en_nxt;

    always_comb begin
        if (wdata[NSRC]) en_nxt = enables | wdata[NSRC-1:0];
        else             en_nxt = enables & ~wdata[NSRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      enables <= '0;
        else if (wr_stb) enables <= en_nxt;
    end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int unsigned NSRC = 7
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    output logic            pending
);
    assign pending = |(flags & enables);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned        NSRC      = IRQ_NSRC,
    parameter int unsigned        AW        = IRQ_AW,
    parameter logic [IRQ_AW-1:0]  FLAG_ADDR = 4'hD,
    parameter logic [IRQ_AW-1:0]  EN_ADDR   = 4'hE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic [NSRC-1:0] src_clr,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [NSRC:0]   reg_wdata,
    output logic [NSRC:0]   reg_rdata,
    output logic            irq
);
    localparam int unsigned DW = NSRC + 1;

    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] en_q;
    logic            en_wr;
    logic            pend;

    assign en_wr = reg_wr && (reg_addr == EN_ADDR);

    irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_p (src_set),
        .clr_p (src_clr),
        .flags (flags_q)
    );

    irq_enable_reg #(.NSRC(NSRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (en_wr),
        .wdata   (reg_wdata),
        .enables (en_q)
    );

    irq_summary #(.NSRC(NSRC)) u_sum (
        .flags   (flags_q),
        .enables (en_q),
        .pending (pend)
    );

    assign irq = pend;

    always_comb begin
        if (reg_addr == FLAG_ADDR)    reg_rdata = {pend, flags_q};
        else if (reg_addr == EN_ADDR) reg_rdata = {1'b1, en_q};
        else                          reg_rdata = {DW{1'b0}};
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int unsigned NSRC = 7,
    parameter int unsigned AW   = 4,
    parameter logic [AW-1:0] FLAG_ADDR = 4'hD,
    parameter logic [AW-1:0] EN_ADDR   = 4'hE
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_set,
    input logic [NSRC-1:0] src_clr,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_wr,
    input logic [NSRC:0]   reg_wdata,
    input logic [NSRC:0]   reg_rdata,
    input logic            irq,
    input logic [NSRC-1:0] flags_q,
    input logic [NSRC-1:0] en_q
);
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_set) |=> ((flags_q & $past(src_set)) == $past(src_set))); // R4
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src_clr & ~src_set)) |=> ((flags_q & $past(src_clr & ~src_set)) == '0)); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set == '0 && src_clr == '0) |=> $stable(flags_q)); // R2
    AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_ADDR && reg_wdata[NSRC])
        |=> ((en_q & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0]))); // R5
    AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == EN_ADDR && !reg_wdata[NSRC])
        |=> ((en_q & $past(reg_wdata[NSRC-1:0])) == '0)); // R6
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == EN_ADDR) |=> $stable(en_q)); // R10
    AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == FLAG_ADDR) |-> (reg_rdata[NSRC] == irq)); // R8
    AST_EN_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == EN_ADDR) |-> reg_rdata[NSRC]); // R9
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(
    .NSRC(NSRC), .AW(AW), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_set   (src_set),
    .src_clr   (src_clr),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .flags_q   (flags_q),
    .en_q      (en_q)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_set = '0;
    logic [6:0] src_clr = '0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [6:0]  m_flags = '0;
    logic [6:0]  m_en = '0;

    always #4 clk = ~clk;   // 125 MHz

    irq_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic exp_irq(input logic [6:0] f, input logic [6:0] e);
        return |(f & e);
    endfunction

    function automatic logic [7:0] exp_read(input logic [3:0] a, input logic [6:0] f,
                                            input logic [6:0] e);
        if (a == 4'hD)      return {exp_irq(f, e), f};
        else if (a == 4'hE) return {1'b1, e};
        else                return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        reg_addr = 4'hD; #0.5;
        check({req, " flag read (R8)"}, reg_rdata, exp_read(4'hD, m_flags, m_en));
        check({req, " irq (R7)"}, {7'd0, irq}, {7'd0, exp_irq(m_flags, m_en)});
        reg_addr = 4'hE; #0.5;
        check({req, " enable read (R9)"}, reg_rdata, exp_read(4'hE, m_flags, m_en));
    endtask

    task automatic cycle(input logic [6:0] s, input logic [6:0] c, input logic w,
                         input logic [3:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        src_set = s; src_clr = c; reg_wr = w; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        src_set = '0; src_clr = '0; reg_wr = 1'b0;
        m_flags = (m_flags & ~c) | s;
        if (w && a == 4'hE) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        check_all(req);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        #10; rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");
        for (int a = 0; a < 16; a++) begin
            if (a != 13 && a != 14) begin
                reg_addr = a[3:0]; #0.1;
                check("R11 unmapped read", reg_rdata, 8'h00);
            end
        end
        cycle(7'h01, 0, 1'b0, 4'h0, 8'h00, "R2 set src0, disabled");
        cycle(0, 0, 1'b1, 4'hE, 8'h81, "R5 write 81");
        cycle(0, 0, 1'b1, 4'hE, 8'h01, "R6 write 01");
        cycle(7'h40, 0, 1'b1, 4'hE, 8'hC0, "R2 timer1 bit6");
        cycle(0, 7'h40, 1'b0, 4'h0, 8'h00, "R3 clear bit6");
        cycle(7'h22, 7'h22, 1'b0, 4'h0, 8'h00, "R4 set wins");
        cycle(0, 0, 1'b1, 4'hD, 8'hFF, "R10 write to flag addr");
        cycle(0, 0, 1'b1, 4'h3, 8'hFF, "R10 write other addr");
        cycle(0, 0, 1'b1, 4'hE, 8'hFF, "R5 enable all");
        cycle(0, 0, 1'b1, 4'hE, 8'h0A, "R6 partial clear");
        cycle(0, 7'h7F, 1'b0, 4'h0, 8'h00, "R3 clear all");
        for (int i = 0; i < 400; i++) begin
            logic [6:0] s, c;
            logic       w;
            logic [3:0] a;
            s = 7'($urandom) & 7'($urandom) & 7'($urandom);
            c = 7'($urandom) & 7'($urandom);
            w = ($urandom % 3) != 0;
            a = (($urandom % 2) != 0) ? 4'hE : 4'($urandom);
            cycle(s, c, w, a, 8'($urandom), "R2-R10 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule